// File: doc/BRIEF.md
# Transmit Timestamp Capture Memory

This block holds the transmit timestamps of a set of ports. Each port owns a fixed number of slots. A local 64-bit timer, which follows the low 64 bits of the master time counter, comes in as a plain input. An outgoing packet that wants a timestamp produces a capture request naming a port and a slot. The block then stores a 40-bit window of the timer in that slot and marks the slot valid.

Software reaches the slots through a simple address/data register port. Each slot has two halves. The low half holds capture bits 31:0 and the high half holds bits 39:32. A per-port status word shows the valid flag of every slot, plus two sticky error flags. Software frees a slot by writing zero to both of its halves. The block refuses to overwrite a slot that is still valid.

The capture requests form a valid/ready stream. A request transfers on any rising edge where `cap_valid` and `cap_ready` are both high. `cap_ready` is low only while reset is asserted, so the block never applies back-pressure in normal operation. A request to a full slot or to an out-of-range slot is still accepted, then dropped and flagged.

Top module: `ts_capture_mem`

## Requirements
- R1: While and after reset, every slot is invalid and every low and high register reads zero. Both status words read zero and `reg_rdata` is zero.
- R2: An accepted request for an in-range slot that is not valid stores bits [CAP_LSB+39:CAP_LSB] of `lcl_time`, sampled at the accepting edge, and sets that slot's valid flag. The default CAP_LSB is 8.
- R3: `reg_addr` is {bank[1:0], port, slot}. Bank 0 returns capture bits 31:0 and bank 1 returns capture bits 39:32 in [7:0], with zeros above. Bank 2 is the port status word and bank 3 reads zero. A read returns its data on `reg_rdata` one cycle after the strobe, and `reg_rdata` holds its value until the next read.
- R4: A slot's valid flag clears only after a zero has been written to each of its two halves, in either order and with any gap between them. A zero write also sets that half to zero. A nonzero write to a half changes nothing.
- R5: A request for a slot that is already valid is dropped. The stored data stays unchanged, and the sticky overflow flag (status bit 31) of that port is set.
- R6: A request whose slot index is NUM_SLOTS or more is dropped, and the sticky range flag (status bit 30) of that port is set. Reads of such a slot return zero.
- R7: Status bits [NUM_SLOTS-1:0] show the port's valid flags. Writing a 1 to bit 31 or bit 30 of the status word clears that flag. If a new error arrives in the same cycle as the clear, the flag stays set.
- R8: A request to one port never changes the slots or flags of another port.
- R9: If a capture is taken into a slot in the same cycle as a register write to that slot, the capture is stored and the write is discarded.
- R10: `cap_ready` is low during reset and high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_time | input | 64 | Local timer value |
| cap_valid | input | 1 | Capture request valid |
| cap_ready | output | 1 | Capture request ready |
| cap_port | input | PORT_W (1) | Port of the request |
| cap_slot | input | SLOT_W (3) | Slot of the request |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2+PORT_W+SLOT_W (6) | {bank, port, slot} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |

## Verification
The main capture path runs from a vector table. The table covers both ports, the first and last slots, and timer values whose captured window is all zeros, alternating bits or a mixed pattern. This separates bit-slicing errors and low/high swaps from errors in port or slot decoding.

Directed tests follow the table. A repeat capture shows that a full slot is protected and its data stays unchanged. An out-of-range index shows that the range flag is kept apart from the overflow flag. A zero write to one half, then a nonzero write, then a zero write to the other half shows that both zeros are needed. A capture that coincides with a write shows which of the two wins.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int TS_W    = 40;
  localparam int LO_W    = 32;
  localparam int HI_W    = TS_W - LO_W;
  localparam int OVF_BIT = 31;
  localparam int RNG_BIT = 30;

  typedef enum logic [1:0] {
    BANK_LO   = 2'd0,
    BANK_HI   = 2'd1,
    BANK_STAT = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;
endpackage

// File: rtl/ts_slot.sv
module ts_slot
  import ts_cap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_hit,
  input  logic [TS_W-1:0] cap_data,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [31:0]     wr_data,
  output logic [LO_W-1:0] lo_q,
  output logic [HI_W-1:0] hi_q,
  output logic            valid_q,
  output logic            cap_drop
);
  logic mark_lo, mark_hi;
  logic wr_zero, take, nxt_lo, nxt_hi;

  assign wr_zero  = (wr_data == 32'd0);
  assign take     = cap_hit & ~valid_q;
  assign cap_drop = cap_hit & valid_q;
  assign nxt_lo   = mark_lo | (wr_lo & wr_zero);
  assign nxt_hi   = mark_hi | (wr_hi & wr_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      valid_q <= 1'b0;
      mark_lo <= 1'b0;
      mark_hi <= 1'b0;
    end else if (take) begin
      lo_q    <= cap_data[LO_W-1:0];
      hi_q    <= cap_data[TS_W-1:LO_W];
      valid_q <= 1'b1;
      mark_lo <= 1'b0;
      mark_hi <= 1'b0;
    end else begin
      if (wr_lo && wr_zero) lo_q <= '0;
      if (wr_hi && wr_zero) hi_q <= '0;
      if (nxt_lo && nxt_hi) begin
        valid_q <= 1'b0;
        mark_lo <= 1'b0;
        mark_hi <= 1'b0;
      end else begin
        mark_lo <= nxt_lo;
        mark_hi <= nxt_hi;
      end
    end
  end

  p_take_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit && !valid_q |=> valid_q && lo_q == $past(cap_data[LO_W-1:0]));

  p_drop_keeps_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit && valid_q && !wr_lo && !wr_hi |=> valid_q && $stable(lo_q) && $stable(hi_q));

  p_fall_needs_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |-> $past(wr_lo || wr_hi) && $past(wr_data) == 32'd0);
endmodule

// File: rtl/ts_port_bank.sv
module ts_port_bank
  import ts_cap_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int SLOT_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_fire,
  input  logic [SLOT_W-1:0]         cap_slot,
  input  logic [TS_W-1:0]           cap_data,
  input  logic                      wr_en,
  input  bank_e                     wr_bank,
  input  logic [SLOT_W-1:0]         wr_slot,
  input  logic [31:0]               wr_data,
  output logic [NUM_SLOTS*LO_W-1:0] lo_flat,
  output logic [NUM_SLOTS*HI_W-1:0] hi_flat,
  output logic [NUM_SLOTS-1:0]      valid_vec,
  output logic                      ovf_q,
  output logic                      rng_q
);
  logic                 in_range, stat_wr, any_drop;
  logic [NUM_SLOTS-1:0] hit_vec, drop_vec;

  assign in_range = ({1'b0, cap_slot} < (SLOT_W+1)'(NUM_SLOTS));
  assign stat_wr  = wr_en && (wr_bank == BANK_STAT);
  assign any_drop = |drop_vec;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign hit_vec[s] = cap_fire && in_range && (cap_slot == SLOT_W'(s));
    ts_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_hit  (hit_vec[s]),
      .cap_data (cap_data),
      .wr_lo    (wr_en && wr_bank == BANK_LO && wr_slot == SLOT_W'(s)),
      .wr_hi    (wr_en && wr_bank == BANK_HI && wr_slot == SLOT_W'(s)),
      .wr_data  (wr_data),
      .lo_q     (lo_flat[s*LO_W +: LO_W]),
      .hi_q     (hi_flat[s*HI_W +: HI_W]),
      .valid_q  (valid_vec[s]),
      .cap_drop (drop_vec[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      rng_q <= 1'b0;
    end else begin
      if (any_drop)                         ovf_q <= 1'b1;
      else if (stat_wr && wr_data[OVF_BIT]) ovf_q <= 1'b0;
      if (cap_fire && !in_range)            rng_q <= 1'b1;
      else if (stat_wr && wr_data[RNG_BIT]) rng_q <= 1'b0;
    end
  end

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !(stat_wr && wr_data[OVF_BIT]) |=> ovf_q);

  p_range_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire && !in_range |=> rng_q && $stable(valid_vec));

  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/ts_capture_mem.sv
module ts_capture_mem
  import ts_cap_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_SLOTS = 5,
  parameter int CAP_LSB   = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ADDR_W   = 2 + PORT_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       lcl_time,
  input  logic              cap_valid,
  output logic              cap_ready,
  input  logic [PORT_W-1:0] cap_port,
  input  logic [SLOT_W-1:0] cap_slot,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  initial begin
    if (CAP_LSB + TS_W > 64) $error("capture window exceeds the timer");
    if (NUM_SLOTS > RNG_BIT)  $error("too many slots for the status word");
  end

  logic                cap_fire, rd_strobe;
  logic [TS_W-1:0]     cap_data;
  bank_e               a_bank;
  logic [PORT_W-1:0]   a_port;
  logic [SLOT_W-1:0]   a_slot;
  logic [31:0]         rd_next;

  logic [NUM_SLOTS*LO_W-1:0] lo_flat   [NUM_PORTS];
  logic [NUM_SLOTS*HI_W-1:0] hi_flat   [NUM_PORTS];
  logic [NUM_SLOTS-1:0]      valid_vec [NUM_PORTS];
  logic [NUM_PORTS-1:0]      ovf_vec, rng_vec;

  assign cap_ready = rst_n;
  assign cap_fire  = cap_valid && cap_ready;
  assign cap_data  = lcl_time[CAP_LSB +: TS_W];
  assign a_bank    = bank_e'(reg_addr[ADDR_W-1 -: 2]);
  assign a_port    = reg_addr[SLOT_W +: PORT_W];
  assign a_slot    = reg_addr[SLOT_W-1:0];
  assign rd_strobe = reg_en && !reg_we;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ts_port_bank #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_fire  (cap_fire && cap_port == PORT_W'(p)),
      .cap_slot  (cap_slot),
      .cap_data  (cap_data),
      .wr_en     (reg_en && reg_we && a_port == PORT_W'(p)),
      .wr_bank   (a_bank),
      .wr_slot   (a_slot),
      .wr_data   (reg_wdata),
      .lo_flat   (lo_flat[p]),
      .hi_flat   (hi_flat[p]),
      .valid_vec (valid_vec[p]),
      .ovf_q     (ovf_vec[p]),
      .rng_q     (rng_vec[p])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (a_port == PORT_W'(p)) begin
        if (a_bank == BANK_STAT) begin
          rd_next = 32'(valid_vec[p]);
          rd_next[OVF_BIT] = ovf_vec[p];
          rd_next[RNG_BIT] = rng_vec[p];
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
          if (a_slot == SLOT_W'(s)) begin
            if (a_bank == BANK_LO) rd_next = lo_flat[p][s*LO_W +: LO_W];
            if (a_bank == BANK_HI) rd_next = 32'(hi_flat[p][s*HI_W +: HI_W]);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (rd_strobe) reg_rdata <= rd_next;
  end

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && a_bank == BANK_NONE |=> reg_rdata == 32'd0);

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(reg_rdata));
endmodule

// File: tb/test_ts_capture_mem.sv
module test_ts_capture_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] lcl_time = '0;
  logic        cap_valid = 1'b0;
  logic        cap_ready;
  logic [0:0]  cap_port = '0;
  logic [2:0]  cap_slot = '0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ts_capture_mem i_ts_capture_mem (
    .clk(clk), .rst_n(rst_n), .lcl_time(lcl_time), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_port(cap_port), .cap_slot(cap_slot),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // {port, slot, timer}
  localparam logic [67:0] VEC [0:5] = '{
    {1'b0, 3'd0, 64'h0123_4567_89AB_CDEF},
    {1'b0, 3'd4, 64'hFEDC_BA98_7654_3210},
    {1'b1, 3'd2, 64'h0000_00FF_FFFF_FF00},
    {1'b1, 3'd0, 64'h1111_2222_3333_4444},
    {1'b0, 3'd2, 64'h0000_0000_0000_00FF},
    {1'b1, 3'd3, 64'hAAAA_5555_A5A5_5A5A}};

  function automatic logic [5:0] adr(input int bank, input int port, input int slot);
    return {2'(bank), 1'(port), 3'(slot)};
  endfunction
  function automatic logic [31:0] exp_lo(input logic [63:0] t);
    return t[39:8];
  endfunction
  function automatic logic [31:0] exp_hi(input logic [63:0] t);
    return {24'd0, t[47:40]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture(input int port, input int slot, input logic [63:0] t);
    @(negedge clk);
    cap_valid = 1'b1; cap_port = 1'(port); cap_slot = 3'(slot); lcl_time = t;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", 32'(cap_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", 32'(cap_ready), 32'd1);
    chk("R1 rdata reset", reg_rdata, 32'd0);
    rd(adr(2, 0, 0), d); chk("R1 status p0", d, 32'd0);
    rd(adr(2, 1, 0), d); chk("R1 status p1", d, 32'd0);
    rd(adr(0, 1, 4), d); chk("R1 low reg", d, 32'd0);

    // table of captures: R2, R3, R8
    for (int i = 0; i < 6; i++) begin
      capture(int'(VEC[i][67]), int'(VEC[i][66:64]), VEC[i][63:0]);
      rd(adr(0, int'(VEC[i][67]), int'(VEC[i][66:64])), d);
      chk("R2 R3 low half", d, exp_lo(VEC[i][63:0]));
      rd(adr(1, int'(VEC[i][67]), int'(VEC[i][66:64])), d);
      chk("R2 R3 high half", d, exp_hi(VEC[i][63:0]));
    end
    // R8: port 0 slot 0 untouched by port 1 slot 0
    rd(adr(0, 0, 0), d); chk("R8 port isolation", d, exp_lo(VEC[0][63:0]));
    rd(adr(2, 0, 0), d); chk("R7 status p0", d, 32'h0000_0015);
    rd(adr(2, 1, 0), d); chk("R7 status p1", d, 32'h0000_000D);

    // R5 overflow
    capture(0, 0, 64'h9999_8888_7777_6666);
    rd(adr(0, 0, 0), d); chk("R5 data kept", d, exp_lo(VEC[0][63:0]));
    rd(adr(2, 0, 0), d); chk("R5 overflow flag", d, 32'h8000_0015);
    rd(adr(2, 1, 0), d); chk("R8 other port flags", d, 32'h0000_000D);
    wr(adr(2, 0, 0), 32'h8000_0000);
    rd(adr(2, 0, 0), d); chk("R7 overflow w1c", d, 32'h0000_0015);

    // R6 range
    capture(1, 6, 64'h1234_5678_9ABC_DEF0);
    rd(adr(2, 1, 0), d); chk("R6 range flag", d, 32'h4000_000D);
    rd(adr(0, 1, 6), d); chk("R6 out-of-range read", d, 32'd0);
    wr(adr(2, 1, 0), 32'h4000_0000);
    rd(adr(2, 1, 0), d); chk("R7 range w1c", d, 32'h0000_000D);

    // R4 clear sequence on port 0 slot 0
    wr(adr(0, 0, 0), 32'd0);
    rd(adr(2, 0, 0), d); chk("R4 one half keeps valid", d, 32'h0000_0015);
    rd(adr(0, 0, 0), d); chk("R4 low zeroed", d, 32'd0);
    wr(adr(1, 0, 0), 32'h0000_0012);
    rd(adr(1, 0, 0), d); chk("R4 nonzero ignored", d, exp_hi(VEC[0][63:0]));
    rd(adr(2, 0, 0), d); chk("R4 nonzero keeps valid", d, 32'h0000_0015);
    wr(adr(1, 0, 0), 32'd0);
    rd(adr(2, 0, 0), d); chk("R4 both halves clear", d, 32'h0000_0014);
    rd(adr(1, 0, 0), d); chk("R4 high zeroed", d, 32'd0);

    // R2 recapture into freed slot
    t = 64'h0F0E_0D0C_0B0A_0908;
    capture(0, 0, t);
    rd(adr(0, 0, 0), d); chk("R2 recapture", d, exp_lo(t));
    rd(adr(2, 0, 0), d); chk("R2 recapture valid", d, 32'h0000_0015);

    // R9 capture and zero write to the same empty slot in one cycle
    t = 64'h0000_7654_3210_FEDC;
    @(negedge clk);
    cap_valid = 1'b1; cap_port = 1'b0; cap_slot = 3'd1; lcl_time = t;
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = adr(0, 0, 1); reg_wdata = 32'd0;
    @(negedge clk);
    cap_valid = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
    rd(adr(0, 0, 1), d); chk("R9 capture wins", d, exp_lo(t));
    wr(adr(1, 0, 1), 32'd0);
    rd(adr(2, 0, 0), d); chk("R9 write discarded", d, 32'h0000_0017);

    // R3 unmapped bank and read hold
    rd(adr(3, 0, 0), d); chk("R3 unmapped bank", d, 32'd0);
    rd(adr(0, 0, 0), d);
    repeat (3) @(negedge clk);
    chk("R3 rdata holds", reg_rdata, exp_lo(64'h0F0E_0D0C_0B0A_0908));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule